// File: doc/BRIEF.md
# Floating-point operand unpack classifier

This block takes one raw 64-bit register operand and a type code. It converts the operand into one unpacked form that later arithmetic stages share. The type code picks one of four inputs: a signed 32-bit integer, a signed 64-bit integer, an IEEE single or an IEEE double. The unpacked form has these parts:

- a sign bit;
- a 13-bit two's-complement unbiased exponent;
- a 66-bit mantissa whose leading one sits at bit 64, so the value is mant / 2^64 * 2^exp;
- a sticky bit, which is always zero;
- a class code.

Signalling NaNs are made quiet during the unpack. They still stay visible through their class code and through an invalid-operand flag.

The unpack logic is combinational and has one shared normalizer for integers and denormals. A registered valid/ready stage sits behind it, so a result appears one cycle after the operand is accepted.

Top module: `fp_unpack`

## Requirements
- R1: For every defined type code, `sign_o` equals operand bit 63. That is the top bit of the high 32-bit word, also for the 32-bit integer type.
- R2: An integer operand whose value is zero gives class ZERO (code 0), with exponent 0 and mantissa 0.
- R3: A nonzero integer gives class NUM (code 1). Its mantissa is the absolute value shifted so the leading one lands at bit 64, and its exponent is the bit index of that leading one. Type code 0 takes the signed integer from operand bits 31:0. Type code 1 takes all 64 bits.
- R4: IEEE layouts. A single (type code 2) has its exponent in bits 62:55, bias 127 and its fraction in bits 54:32. A double (type code 3) has its exponent in bits 62:52, bias 1023 and its fraction in bits 51:0. A zero exponent field with a zero fraction gives class ZERO with exponent 0 and mantissa 0.
- R5: A zero exponent field with a nonzero fraction is a denormal. Its fraction is placed below bit 64 with no implied one, its exponent starts at 1 minus bias, and it is then normalized to bit 64. Each shift lowers the exponent by one.
- R6: A normal IEEE input gives class NUM and an exponent equal to the field minus the bias. Its mantissa is 1 at bit 64, with the fraction left-aligned directly below it at bit 63 downward.
- R7: An all-ones exponent field with a zero fraction gives class INF (code 2), with exponent 0 and mantissa 0.
- R8: An all-ones exponent field with a nonzero fraction whose top bit is set gives class QNAN (code 3). The fraction is copied unchanged into the mantissa at bit 63 downward, the exponent is 0, and `snan_o` stays low.
- R9: A NaN whose fraction top bit is clear gives class SNAN (code 4). The unit sets mantissa bit 63, keeps the rest of the copied fraction, and raises `snan_o`.
- R10: Type codes 4 to 7 give class ZERO with sign 0, exponent 0 and mantissa 0, and raise `fmt_err_o`. Defined type codes keep `fmt_err_o` low.
- R11: An operand accepted while `in_valid_i` and `in_ready_o` are both high appears at the outputs, with `out_valid_o` high, after the next clock edge. `in_ready_o` is high when the output stage is empty or `out_ready_i` is high. The outputs hold steady while `out_valid_o` is high and `out_ready_i` is low.
- R12: `sticky_o` is always 0, and every class NUM result has mantissa bit 65 clear and bit 64 set.
- R13: After reset, `out_valid_o` is low and `in_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand valid |
| in_ready_o | output | 1 | Unit can accept an operand |
| opnd_i | input | 64 | Raw register operand |
| fmt_i | input | 3 | Type code: 0 int32, 1 int64, 2 single, 3 double |
| out_valid_o | output | 1 | Unpacked result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| sign_o | output | 1 | Sign |
| exp_o | output | 13 | Unbiased exponent, two's complement |
| mant_o | output | 66 | Mantissa, leading one at bit 64 |
| sticky_o | output | 1 | Sticky bit (always 0) |
| class_o | output | 3 | 0 ZERO, 1 NUM, 2 INF, 3 QNAN, 4 SNAN |
| snan_o | output | 1 | Invalid operand: signalling NaN seen |
| fmt_err_o | output | 1 | Undefined type code |

## Verification
The bench targets these corner cases:

- **Most negative integers.** Both widths hold a most negative value, and the int32 type has a sign taken from the unrelated high word. A unit that negated in the wrong width, or took the sign from bit 31, would return a wrong magnitude or sign.
- **Smallest denormals of both formats.** These need the longest normalizing shift. An off-by-one shift count or a missing exponent decrement shows up as a wrong exponent.
- **NaN payloads with and without the quiet bit.** A unit that forgot to set the quiet bit would report QNAN with no flag. One that normalized NaNs or inserted an implied one would alter the payload.
- **Undefined type codes and backpressure.** These catch a unit that leaks arithmetic results, or that overwrites a result still waiting to be taken.

// File: rtl/fpu_unpack_pkg.sv
package fpu_unpack_pkg;
  localparam int MANT_W   = 66;
  localparam int LEAD_POS = 64;
  localparam int EXP_W    = 13;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } cls_e;

  localparam logic [2:0] FMT_I32 = 3'd0;
  localparam logic [2:0] FMT_I64 = 3'd1;
  localparam logic [2:0] FMT_SGL = 3'd2;
  localparam logic [2:0] FMT_DBL = 3'd3;
endpackage

// File: rtl/unp_lzc.sv
module unp_lzc #(
  parameter int W  = 66,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  d_i,
  output logic [CW-1:0] cnt_o
);
  logic found;

  always_comb begin
    cnt_o = CW'(W);
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && d_i[i]) begin
        cnt_o = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/unp_norm.sv
module unp_norm #(
  parameter int MW   = 66,
  parameter int EW   = 13,
  parameter int LEAD = 64
) (
  input  logic [MW-1:0] mant_i,
  input  logic [EW-1:0] exp_i,
  output logic [MW-1:0] mant_o,
  output logic [EW-1:0] exp_o
);
  localparam int CW   = $clog2(MW + 1);
  localparam int HEAD = MW - 1 - LEAD;   // zero bits above the leading one

  logic [CW-1:0] lz;
  logic [CW-1:0] shamt;

  unp_lzc #(.W(MW), .CW(CW)) u_lzc (
    .d_i  (mant_i),
    .cnt_o(lz)
  );

  always_comb begin
    shamt = '0;
    if (mant_i != '0 && lz > CW'(HEAD)) shamt = lz - CW'(HEAD);
    mant_o = mant_i << shamt;
    exp_o  = exp_i - EW'(shamt);
  end
endmodule

// File: rtl/unp_ieee.sv
module unp_ieee
  import fpu_unpack_pkg::*;
#(
  parameter int EFW  = 8,
  parameter int FFW  = 23,
  parameter int MW   = 66,
  parameter int EW   = 13,
  parameter int LEAD = 64
) (
  input  logic [EFW-1:0] ef_i,
  input  logic [FFW-1:0] fr_i,
  output cls_e           cls_o,
  output logic [EW-1:0]  exp_o,
  output logic [MW-1:0]  mant_o,
  output logic           inv_o
);
  localparam int BIAS = (1 << (EFW - 1)) - 1;

  logic [MW-1:0] fr_al;

  assign fr_al = MW'(fr_i) << (LEAD - FFW);

  always_comb begin
    cls_o  = CLS_ZERO;
    exp_o  = '0;
    mant_o = '0;
    inv_o  = 1'b0;
    if (ef_i == '0) begin
      if (fr_i != '0) begin
        cls_o  = CLS_NUM;            // denormal, normalized downstream
        exp_o  = EW'(1 - BIAS);
        mant_o = fr_al;
      end
    end else if (ef_i == '1) begin
      if (fr_i == '0) begin
        cls_o = CLS_INF;
      end else begin
        mant_o = fr_al;
        if (fr_i[FFW-1]) begin
          cls_o = CLS_QNAN;
        end else begin
          cls_o            = CLS_SNAN;
          mant_o[LEAD - 1] = 1'b1;
          inv_o            = 1'b1;
        end
      end
    end else begin
      cls_o        = CLS_NUM;
      exp_o        = EW'(ef_i) - EW'(BIAS);
      mant_o       = fr_al;
      mant_o[LEAD] = 1'b1;
    end
  end
endmodule

// File: rtl/fp_unpack.sv
module fp_unpack
  import fpu_unpack_pkg::*;
#(
  parameter int MW   = MANT_W,
  parameter int EW   = EXP_W,
  parameter int LEAD = LEAD_POS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [63:0]   opnd_i,
  input  logic [2:0]    fmt_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic          sign_o,
  output logic [EW-1:0] exp_o,
  output logic [MW-1:0] mant_o,
  output logic          sticky_o,
  output logic [2:0]    class_o,
  output logic          snan_o,
  output logic          fmt_err_o
);
  localparam int S_EFW = 8;
  localparam int S_FFW = 23;
  localparam int D_EFW = 11;
  localparam int D_FFW = 52;

  // ieee front ends
  cls_e           s_cls, d_cls;
  logic [EW-1:0]  s_exp, d_exp;
  logic [MW-1:0]  s_mant, d_mant;
  logic           s_inv, d_inv;

  unp_ieee #(.EFW(S_EFW), .FFW(S_FFW), .MW(MW), .EW(EW), .LEAD(LEAD)) u_sgl (
    .ef_i  (opnd_i[62 -: S_EFW]),
    .fr_i  (opnd_i[62-S_EFW -: S_FFW]),
    .cls_o (s_cls),
    .exp_o (s_exp),
    .mant_o(s_mant),
    .inv_o (s_inv)
  );

  unp_ieee #(.EFW(D_EFW), .FFW(D_FFW), .MW(MW), .EW(EW), .LEAD(LEAD)) u_dbl (
    .ef_i  (opnd_i[62 -: D_EFW]),
    .fr_i  (opnd_i[D_FFW-1:0]),
    .cls_o (d_cls),
    .exp_o (d_exp),
    .mant_o(d_mant),
    .inv_o (d_inv)
  );

  // integer magnitudes
  logic [31:0] mag32;
  logic [63:0] mag64;
  assign mag32 = opnd_i[31] ? (~opnd_i[31:0] + 32'd1) : opnd_i[31:0];
  assign mag64 = opnd_i[63] ? (~opnd_i + 64'd1) : opnd_i;

  cls_e          pre_cls;
  logic [EW-1:0] pre_exp;
  logic [MW-1:0] pre_mant;
  logic          pre_inv, pre_sgn, pre_err;

  always_comb begin
    pre_cls  = CLS_ZERO;
    pre_exp  = '0;
    pre_mant = '0;
    pre_inv  = 1'b0;
    pre_sgn  = opnd_i[63];
    pre_err  = 1'b0;
    case (fmt_i)
      FMT_I32: if (mag32 != '0) begin
        pre_cls  = CLS_NUM;
        pre_exp  = EW'(LEAD);
        pre_mant = MW'(mag32);
      end
      FMT_I64: if (mag64 != '0) begin
        pre_cls  = CLS_NUM;
        pre_exp  = EW'(LEAD);
        pre_mant = MW'(mag64);
      end
      FMT_SGL: begin
        pre_cls  = s_cls;
        pre_exp  = s_exp;
        pre_mant = s_mant;
        pre_inv  = s_inv;
      end
      FMT_DBL: begin
        pre_cls  = d_cls;
        pre_exp  = d_exp;
        pre_mant = d_mant;
        pre_inv  = d_inv;
      end
      default: begin
        pre_sgn = 1'b0;
        pre_err = 1'b1;
      end
    endcase
  end

  // shared normalizer
  logic [MW-1:0] nrm_mant, fin_mant;
  logic [EW-1:0] nrm_exp, fin_exp;

  unp_norm #(.MW(MW), .EW(EW), .LEAD(LEAD)) u_norm (
    .mant_i(pre_mant),
    .exp_i (pre_exp),
    .mant_o(nrm_mant),
    .exp_o (nrm_exp)
  );

  assign fin_mant = (pre_cls == CLS_NUM) ? nrm_mant : pre_mant;
  assign fin_exp  = (pre_cls == CLS_NUM) ? nrm_exp  : pre_exp;

  // output stage
  logic          vld_q, sign_q, inv_q, err_q;
  logic [EW-1:0] exp_q;
  logic [MW-1:0] mant_q;
  logic [2:0]    cls_q;
  logic          accept;

  assign in_ready_o = !vld_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      sign_q <= 1'b0;
      inv_q  <= 1'b0;
      err_q  <= 1'b0;
      exp_q  <= '0;
      mant_q <= '0;
      cls_q  <= CLS_ZERO;
    end else if (accept) begin
      vld_q  <= 1'b1;
      sign_q <= pre_sgn;
      inv_q  <= pre_inv;
      err_q  <= pre_err;
      exp_q  <= fin_exp;
      mant_q <= fin_mant;
      cls_q  <= pre_cls;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign sign_o      = sign_q;
  assign exp_o       = exp_q;
  assign mant_o      = mant_q;
  assign sticky_o    = 1'b0;
  assign class_o     = cls_q;
  assign snan_o      = inv_q;
  assign fmt_err_o   = err_q;

  a_r12_num_leading_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && cls_q == CLS_NUM) |-> (mant_q[LEAD] && (mant_q >> (LEAD + 1)) == '0));

  a_r9_flag_matches_snan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (inv_q == (cls_q == CLS_SNAN)));

  a_r9_nan_quiet_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && (cls_q == CLS_QNAN || cls_q == CLS_SNAN)) |-> mant_q[LEAD-1]);

  a_r10_err_gives_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && err_q) |-> (cls_q == CLS_ZERO && !sign_q && mant_q == '0));

  a_r11_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !out_ready_i) |=> (vld_q && $stable(mant_q) && $stable(cls_q) && $stable(exp_q)));

  a_r11_accept_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> vld_q);
endmodule

// File: tb/tb_fp_unpack.sv
`timescale 1ns/1ps
module tb_fp_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] opnd = '0;
  logic [2:0]  fmt = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        sign;
  logic [12:0] exp_v;
  logic [65:0] mant;
  logic        sticky;
  logic [2:0]  cls;
  logic        snan;
  logic        ferr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fp_unpack dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .opnd_i(opnd), .fmt_i(fmt), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .sign_o(sign), .exp_o(exp_v), .mant_o(mant), .sticky_o(sticky),
    .class_o(cls), .snan_o(snan), .fmt_err_o(ferr)
  );

  task automatic model(input logic [63:0] op, input logic [2:0] t,
                       output logic s, output logic [12:0] e, output logic [65:0] m,
                       output logic [2:0] c, output logic nv, output logic er);
    logic [63:0] mag;
    logic [51:0] fr;
    int ef, bias, emax, ee;
    s = op[63]; e = '0; m = '0; c = 3'd0; nv = 1'b0; er = 1'b0;
    if (t == 3'd0 || t == 3'd1) begin
      if (t == 3'd0) mag = op[31] ? (64'h1_0000_0000 - {32'd0, op[31:0]}) : {32'd0, op[31:0]};
      else           mag = op[63] ? (64'd0 - op) : op;
      if (mag != 0) begin
        c = 3'd1; m = {2'b00, mag}; ee = 64;
        while (!m[64]) begin m = m << 1; ee--; end
        e = 13'(ee);
      end
    end else if (t == 3'd2 || t == 3'd3) begin
      if (t == 3'd2) begin ef = int'(op[62:55]); fr = {op[54:32], 29'd0}; bias = 127;  emax = 255;  end
      else           begin ef = int'(op[62:52]); fr = op[51:0];           bias = 1023; emax = 2047; end
      if (ef == 0) begin
        if (fr != 0) begin
          c = 3'd1; m = {2'b00, fr, 12'd0}; ee = 1 - bias;
          while (!m[64]) begin m = m << 1; ee--; end
          e = 13'(ee);
        end
      end else if (ef == emax) begin
        if (fr == 0) c = 3'd2;
        else begin
          m = {2'b00, fr, 12'd0};
          if (m[63]) c = 3'd3;
          else begin m[63] = 1'b1; c = 3'd4; nv = 1'b1; end
        end
      end else begin
        c = 3'd1; m = {2'b01, fr, 12'd0}; e = 13'(ef - bias);
      end
    end else begin
      s = 1'b0; er = 1'b1;
    end
  endtask

  task automatic compare(input string tag);
    logic s, nv, er; logic [12:0] e; logic [65:0] m; logic [2:0] c;
    model(opnd, fmt, s, e, m, c, nv, er);
    checks++;
    if (!out_valid || sign !== s || exp_v !== e || mant !== m || cls !== c ||
        snan !== nv || ferr !== er || sticky !== 1'b0) begin
      errors++;
      $display("FAIL %s op=%h fmt=%0d: got v=%b s=%b e=%h m=%h c=%0d nv=%b er=%b st=%b exp s=%b e=%h m=%h c=%0d nv=%b er=%b",
               tag, opnd, fmt, out_valid, sign, exp_v, mant, cls, snan, ferr, sticky,
               s, e, m, c, nv, er);
    end
  endtask

  task automatic run_one(input logic [63:0] op, input logic [2:0] t, input string tag);
    @(negedge clk);
    opnd = op; fmt = t; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare(tag);
  endtask

  task automatic check_bit(input logic act, input logic expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: got %b exp %b", tag, act, expv);
    end
  endtask

  function automatic string tag_for(input logic [2:0] t);
    case (t)
      3'd0, 3'd1: return "R1 R2 R3 random int";
      3'd2, 3'd3: return "R4 R5 R6 R7 R8 R9 R12 random ieee";
      default:    return "R10 random bad fmt";
    endcase
  endfunction

  initial begin
    #(4ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] op;
    logic [2:0]  t;
    logic [63:0] hold_op;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check_bit(out_valid, 1'b0, "R13 reset out_valid");
    check_bit(in_ready, 1'b1, "R13 reset in_ready");
    rst_n = 1'b1;

    // integers
    run_one(64'h8000_0000_0000_0000, 3'd0, "R2 int32 zero, R1 sign from high word");
    run_one(64'h0000_0000_0000_0000, 3'd1, "R2 int64 zero");
    run_one(64'h0000_0000_FFFF_FFFF, 3'd0, "R3 int32 minus one");
    run_one(64'h0000_0000_8000_0000, 3'd0, "R3 int32 most negative");
    run_one(64'h8000_0000_0000_0000, 3'd1, "R3 int64 most negative");
    run_one(64'h0000_0000_0000_0005, 3'd1, "R3 int64 five");
    run_one(64'hFFFF_FFFF_0000_0001, 3'd0, "R1 R3 int32 sign quirk");
    // single
    run_one(64'h0000_0000_1234_5678, 3'd2, "R4 single plus zero");
    run_one(64'h8000_0000_0000_0000, 3'd2, "R4 R1 single minus zero");
    run_one(64'h3F80_0000_0000_0000, 3'd2, "R6 single one");
    run_one(64'hC2F6_E979_0000_0000, 3'd2, "R6 single normal");
    run_one(64'h0000_0001_0000_0000, 3'd2, "R5 single min denormal");
    run_one(64'h807F_FFFF_0000_0000, 3'd2, "R5 single max denormal");
    run_one(64'h7F80_0000_0000_0000, 3'd2, "R7 single inf");
    run_one(64'h7FC0_0001_0000_0000, 3'd2, "R8 single qnan");
    run_one(64'hFF80_0001_0000_0000, 3'd2, "R9 single snan");
    // double
    run_one(64'h3FF0_0000_0000_0000, 3'd3, "R6 double one");
    run_one(64'h7FEF_FFFF_FFFF_FFFF, 3'd3, "R6 double max");
    run_one(64'h0000_0000_0000_0001, 3'd3, "R5 double min denormal");
    run_one(64'h8000_0000_0000_0000, 3'd3, "R4 double minus zero");
    run_one(64'hFFF0_0000_0000_0000, 3'd3, "R7 double minus inf");
    run_one(64'h7FF8_0000_0000_0000, 3'd3, "R8 double qnan");
    run_one(64'h7FF4_0000_0000_0001, 3'd3, "R9 double snan");
    // undefined codes
    run_one(64'hFFFF_FFFF_FFFF_FFFF, 3'd5, "R10 undefined fmt");
    run_one(64'h3FF0_0000_0000_0000, 3'd7, "R10 undefined fmt");

    // backpressure
    @(negedge clk);
    hold_op = 64'h4000_0000_0000_0000;
    opnd = hold_op; fmt = 3'd3; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    check_bit(in_ready, 1'b0, "R11 ready low while stalled");
    compare("R11 first result");
    opnd = 64'h3F80_0000_0000_0000; fmt = 3'd2;
    @(negedge clk);
    opnd = hold_op; fmt = 3'd3;
    compare("R11 held during stall");
    check_bit(in_ready, 1'b0, "R11 ready still low");
    opnd = 64'h3F80_0000_0000_0000; fmt = 3'd2; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    compare("R11 second result after release");
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R11 drained");
    check_bit(in_ready, 1'b1, "R11 ready when empty");

    // random
    for (int k = 0; k < 3000; k++) begin
      int sel;
      t = 3'($urandom % 9);
      if (t > 3'd3 && ($urandom % 4) != 0) t = 3'($urandom % 4);
      op = {$urandom, $urandom};
      sel = int'($urandom % 5);
      if (t == 3'd2) begin
        if (sel == 0) op[62:55] = '0;
        if (sel == 1) op[62:55] = '1;
        if (sel == 2 && ($urandom % 2) == 0) op[54:32] = '0;
        if (sel == 3) op[54:32] = 23'($urandom % 8);
      end else if (t == 3'd3) begin
        if (sel == 0) op[62:52] = '0;
        if (sel == 1) op[62:52] = '1;
        if (sel == 2 && ($urandom % 2) == 0) op[51:0] = '0;
        if (sel == 3) op[51:0] = 52'($urandom % 8);
      end else if (t == 3'd0 && sel == 0) begin
        op[31:0] = 32'($urandom % 4) - 32'd2;
      end else if (t == 3'd1 && sel == 0) begin
        op = 64'($urandom % 4) - 64'd2;
      end
      run_one(op, t, tag_for(t));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule